// File: doc/BRIEF.md
# Keyboard Controller Host Command Processor

This block is the host side of a PC-style keyboard controller. The host reaches it through two byte-wide ports. A single address bit selects between them: 0 selects the data port and 1 selects the command/status port. A write to the command port is decoded as a controller command. A write to the data port either completes a command that is waiting for an argument, or goes straight on to the keyboard device. A read of the status port returns the status byte combinationally.

The block holds the mode byte, the status byte and the output-port byte. From the output-port byte it drives the A20 gate line and a one-cycle system reset request. Bytes that the host is to read back are pushed, one cycle after the write, to the output-buffer logic. Each pushed byte is tagged as keyboard or auxiliary. Bytes meant for the keyboard or the mouse device leave on strobed forwarding outputs.

Waiting commands are held in a finite state machine. Its states are IDLE, WAIT_MODE, WAIT_OPORT, WAIT_OBUF_KBD, WAIT_OBUF_AUX and WAIT_MOUSE. An arming command moves it from any state to the matching WAIT state. Any data-port write moves it back to IDLE. Every other command leaves the state unchanged.

Top module: `kbc_cmd_proc`

## Requirements
- R1: After reset, the mode byte is 0x03, the status byte reads 0x18 (with both buffer-full inputs low), the output port is 0xCF, the A20 line is 1 and the error flag is 0.
- R2: The status port bit 0 follows `obf_full_i`, bit 5 follows `obf_aux_i`, and bit 2 is the self-test flag; all three are visible in the same cycle.
- R3: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 arm a pending write. The next data-port write completes it and returns the state to IDLE. Other commands written in between leave the pending write armed.
- R4: A data-port write with nothing pending appears on `kbd_fwd_valid`/`dev_data` one cycle later.
- R5: The data byte after 0x60 loads the mode byte. After 0xD2 it is pushed with `push_aux`=0. After 0xD3 it is pushed with `push_aux`=1. After 0xD4 it is strobed on `mouse_fwd_valid`.
- R6: Read-back commands push a keyboard-channel byte: 0x20 pushes the mode, 0xD0 pushes the output port (bits 4 and 5 replaced by the buffer-full inputs), 0xC0 pushes 0x80, 0xA9 and 0xAB push 0x00, and 0xAA pushes 0x55 and sets status bit 2.
- R7: 0xA7 and 0xA8 set and clear mode bit 5. 0xAD and 0xAE set and clear mode bit 4.
- R8: 0xDF sets output-port bit 1 and raises A20. 0xDD clears that bit and lowers A20.
- R9: The data byte after 0xD1 loads the output port, and A20 follows its bit 1. If its bit 0 is 0, `sys_reset_req` pulses for exactly one cycle.
- R10: A command whose upper four bits are 1111 acts as a reset request (one-cycle pulse) when bit 0 is 0, and does nothing when bit 0 is 1.
- R11: An unrecognised command changes no register and produces no output strobe, but sets the sticky `cmd_err` flag, which only reset clears.
- R12: Every push, forward or reset pulse appears in the cycle after the write that caused it, and at most one of push, keyboard forward and mouse forward is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe, one cycle per byte |
| host_sel | input | 1 | Port select: 0 data, 1 command/status |
| host_wdata | input | 8 | Byte written by the host |
| stat_rdata | output | 8 | Status byte for a status-port read |
| obf_full_i | input | 1 | Output buffer holds a byte |
| obf_aux_i | input | 1 | Byte in the output buffer is auxiliary |
| push_valid | output | 1 | Push a byte into the output buffer |
| push_data | output | 8 | Byte pushed |
| push_aux | output | 1 | Pushed byte belongs to the auxiliary channel |
| kbd_fwd_valid | output | 1 | Byte forwarded to the keyboard device |
| mouse_fwd_valid | output | 1 | Byte forwarded to the mouse device |
| dev_data | output | 8 | Forwarded byte |
| a20_gate | output | 1 | A20 gate line |
| sys_reset_req | output | 1 | One-cycle system reset request |
| cmd_err | output | 1 | Sticky flag for an unrecognised command |

## Verification
The assertions assume that the host never writes on two consecutive cycles. This matters because a reset pulse is one cycle long, and any strobe must trace back to a write on the previous cycle. The assertions also assume that the buffer-full inputs are driven to known values. The stimulus waits at least one idle cycle between any two writes, and it changes the buffer-full inputs only between writes. Every expected push, forward and reset pulse is queued before the write that should cause it. A strobe that arrives with nothing queued is reported as an error.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        PW_IDLE,
        PW_MODE,
        PW_OPORT,
        PW_OBUF_KBD,
        PW_OBUF_AUX,
        PW_MOUSE
    } pend_e;

    typedef enum logic [4:0] {
        ACT_RD_MODE,
        ACT_ARM_MODE,
        ACT_ARM_OPORT,
        ACT_ARM_OBK,
        ACT_ARM_OBA,
        ACT_ARM_MOUSE,
        ACT_AUX_OFF,
        ACT_AUX_ON,
        ACT_KBD_OFF,
        ACT_KBD_ON,
        ACT_PUSH_ZERO,
        ACT_SELF_TEST,
        ACT_RD_INPORT,
        ACT_RD_OPORT,
        ACT_A20_ON,
        ACT_A20_OFF,
        ACT_SYS_RST,
        ACT_NOP,
        ACT_BAD
    } act_e;
endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
    import kbc_pkg::*;
(
    input  logic [BYTE_W-1:0] cmd_i,
    output act_e              act_o
);
    logic [BYTE_W-1:0] folded;

    always_comb begin
        folded = cmd_i;
        if (cmd_i[BYTE_W-1 -: 4] == 4'hF)
            folded = cmd_i[0] ? 8'hFF : 8'hFE;
    end

    always_comb begin
        unique case (folded)
            8'h20:   act_o = ACT_RD_MODE;
            8'h60:   act_o = ACT_ARM_MODE;
            8'hD1:   act_o = ACT_ARM_OPORT;
            8'hD2:   act_o = ACT_ARM_OBK;
            8'hD3:   act_o = ACT_ARM_OBA;
            8'hD4:   act_o = ACT_ARM_MOUSE;
            8'hA7:   act_o = ACT_AUX_OFF;
            8'hA8:   act_o = ACT_AUX_ON;
            8'hAD:   act_o = ACT_KBD_OFF;
            8'hAE:   act_o = ACT_KBD_ON;
            8'hA9,
            8'hAB:   act_o = ACT_PUSH_ZERO;
            8'hAA:   act_o = ACT_SELF_TEST;
            8'hC0:   act_o = ACT_RD_INPORT;
            8'hD0:   act_o = ACT_RD_OPORT;
            8'hDF:   act_o = ACT_A20_ON;
            8'hDD:   act_o = ACT_A20_OFF;
            8'hFE:   act_o = ACT_SYS_RST;
            8'hFF:   act_o = ACT_NOP;
            default: act_o = ACT_BAD;
        endcase
    end
endmodule

// File: rtl/kbc_pend_fsm.sv
module kbc_pend_fsm
    import kbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              dat_wr,
    input  act_e              act,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] mode_i,
    input  logic [BYTE_W-1:0] oport_view_i,
    output logic              ld_mode,
    output logic              ld_oport,
    output logic              push_v,
    output logic [BYTE_W-1:0] push_d,
    output logic              push_a,
    output logic              kfwd_v,
    output logic              mfwd_v,
    output logic [BYTE_W-1:0] fwd_d
);
    pend_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PW_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (dat_wr) begin
            state_d = PW_IDLE;
        end else if (cmd_wr) begin
            unique case (act)
                ACT_ARM_MODE:  state_d = PW_MODE;
                ACT_ARM_OPORT: state_d = PW_OPORT;
                ACT_ARM_OBK:   state_d = PW_OBUF_KBD;
                ACT_ARM_OBA:   state_d = PW_OBUF_AUX;
                ACT_ARM_MOUSE: state_d = PW_MOUSE;
                default:       state_d = state_q;
            endcase
        end
    end

    assign ld_mode  = dat_wr && (state_q == PW_MODE);
    assign ld_oport = dat_wr && (state_q == PW_OPORT);

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            push_v <= 1'b0;
            push_d <= '0;
            push_a <= 1'b0;
            kfwd_v <= 1'b0;
            mfwd_v <= 1'b0;
            fwd_d  <= '0;
        end else begin
            push_v <= 1'b0;
            push_a <= 1'b0;
            kfwd_v <= 1'b0;
            mfwd_v <= 1'b0;
            if (cmd_wr) begin
                unique case (act)
                    ACT_RD_MODE:   begin push_v <= 1'b1; push_d <= mode_i;       end
                    ACT_RD_OPORT:  begin push_v <= 1'b1; push_d <= oport_view_i; end
                    ACT_RD_INPORT: begin push_v <= 1'b1; push_d <= 8'h80;        end
                    ACT_PUSH_ZERO: begin push_v <= 1'b1; push_d <= 8'h00;        end
                    ACT_SELF_TEST: begin push_v <= 1'b1; push_d <= 8'h55;        end
                    default: ;
                endcase
            end else if (dat_wr) begin
                unique case (state_q)
                    PW_IDLE:     begin kfwd_v <= 1'b1; fwd_d <= wdata; end
                    PW_MOUSE:    begin mfwd_v <= 1'b1; fwd_d <= wdata; end
                    PW_OBUF_KBD: begin push_v <= 1'b1; push_d <= wdata; end
                    PW_OBUF_AUX: begin push_v <= 1'b1; push_d <= wdata; push_a <= 1'b1; end
                    default: ;
                endcase
            end
        end
    end

    assert_pend_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dat_wr |=> (state_q == PW_IDLE));
    assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({push_v, kfwd_v, mfwd_v}));
endmodule

// File: rtl/kbc_ctl_regs.sv
module kbc_ctl_regs
    import kbc_pkg::*;
#(
    parameter logic [BYTE_W-1:0] MODE_RST  = 8'h03,
    parameter logic [BYTE_W-1:0] STAT_RST  = 8'h18,
    parameter logic [BYTE_W-1:0] OPORT_RST = 8'hCF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  act_e              act,
    input  logic              ld_mode,
    input  logic              ld_oport,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] mode_q,
    output logic [BYTE_W-1:0] stat_q,
    output logic [BYTE_W-1:0] oport_q,
    output logic              rst_req_q,
    output logic              err_q
);
    localparam int AUX_DIS_BIT = 5;
    localparam int KBD_DIS_BIT = 4;
    localparam int SELF_BIT    = 2;
    localparam int A20_BIT     = 1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MODE_RST;
            stat_q    <= STAT_RST;
            oport_q   <= OPORT_RST;
            rst_req_q <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            rst_req_q <= 1'b0;
            if (ld_mode)  mode_q <= wdata;
            if (ld_oport) begin
                oport_q   <= wdata;
                rst_req_q <= ~wdata[0];
            end
            if (cmd_wr) begin
                unique case (act)
                    ACT_AUX_OFF:   mode_q[AUX_DIS_BIT] <= 1'b1;
                    ACT_AUX_ON:    mode_q[AUX_DIS_BIT] <= 1'b0;
                    ACT_KBD_OFF:   mode_q[KBD_DIS_BIT] <= 1'b1;
                    ACT_KBD_ON:    mode_q[KBD_DIS_BIT] <= 1'b0;
                    ACT_SELF_TEST: stat_q[SELF_BIT]    <= 1'b1;
                    ACT_A20_ON:    oport_q[A20_BIT]    <= 1'b1;
                    ACT_A20_OFF:   oport_q[A20_BIT]    <= 1'b0;
                    ACT_SYS_RST:   rst_req_q           <= 1'b1;
                    ACT_BAD:       err_q               <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    assert_a20_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && act == ACT_A20_ON) |=> oport_q[A20_BIT]);
    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
    assert_selftest_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[SELF_BIT] |=> stat_q[SELF_BIT]);
endmodule

// File: rtl/kbc_cmd_proc.sv
module kbc_cmd_proc
    import kbc_pkg::*;
#(
    parameter logic [BYTE_W-1:0] MODE_RST  = 8'h03,
    parameter logic [BYTE_W-1:0] STAT_RST  = 8'h18,
    parameter logic [BYTE_W-1:0] OPORT_RST = 8'hCF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic              host_sel,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] stat_rdata,
    input  logic              obf_full_i,
    input  logic              obf_aux_i,
    output logic              push_valid,
    output logic [BYTE_W-1:0] push_data,
    output logic              push_aux,
    output logic              kbd_fwd_valid,
    output logic              mouse_fwd_valid,
    output logic [BYTE_W-1:0] dev_data,
    output logic              a20_gate,
    output logic              sys_reset_req,
    output logic              cmd_err
);
    localparam int OBF_BIT  = 0;
    localparam int AOBF_BIT = 5;
    localparam int PO_OBF   = 4;
    localparam int PO_AOBF  = 5;

    logic              cmd_wr, dat_wr, ld_mode, ld_oport;
    act_e              act;
    logic [BYTE_W-1:0] mode_q, stat_q, oport_q;
    logic [BYTE_W-1:0] oport_view;

    assign cmd_wr = host_we &&  host_sel;
    assign dat_wr = host_we && !host_sel;

    kbc_cmd_decode u_dec (
        .cmd_i (host_wdata),
        .act_o (act)
    );

    kbc_ctl_regs #(
        .MODE_RST  (MODE_RST),
        .STAT_RST  (STAT_RST),
        .OPORT_RST (OPORT_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .act       (act),
        .ld_mode   (ld_mode),
        .ld_oport  (ld_oport),
        .wdata     (host_wdata),
        .mode_q    (mode_q),
        .stat_q    (stat_q),
        .oport_q   (oport_q),
        .rst_req_q (sys_reset_req),
        .err_q     (cmd_err)
    );

    always_comb begin
        oport_view          = oport_q;
        oport_view[PO_OBF]  = obf_full_i;
        oport_view[PO_AOBF] = obf_aux_i;
        stat_rdata           = stat_q;
        stat_rdata[OBF_BIT]  = obf_full_i;
        stat_rdata[AOBF_BIT] = obf_aux_i;
    end

    kbc_pend_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_wr       (cmd_wr),
        .dat_wr       (dat_wr),
        .act          (act),
        .wdata        (host_wdata),
        .mode_i       (mode_q),
        .oport_view_i (oport_view),
        .ld_mode      (ld_mode),
        .ld_oport     (ld_oport),
        .push_v       (push_valid),
        .push_d       (push_data),
        .push_a       (push_aux),
        .kfwd_v       (kbd_fwd_valid),
        .mfwd_v       (mouse_fwd_valid),
        .fwd_d        (dev_data)
    );

    assign a20_gate = oport_q[1];

    assert_rst_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |-> $past(host_we));
    assert_rst_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |=> !sys_reset_req);
endmodule

// File: tb/test_kbc_cmd_proc.sv
`timescale 1ns/1ps
module test_kbc_cmd_proc;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_we = 1'b0, host_sel = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] stat_rdata;
    logic       obf_full_i = 1'b0, obf_aux_i = 1'b0;
    logic       push_valid, push_aux, kbd_fwd_valid, mouse_fwd_valid;
    logic [7:0] push_data, dev_data;
    logic       a20_gate, sys_reset_req, cmd_err;

    int n_chk = 0, n_fail = 0;
    logic [10:0] exp_q[$];   // {kind[1:0], aux, data}; kind 0 push, 1 kbd fwd, 2 mouse fwd, 3 reset

    always #2.5 clk = ~clk;

    kbc_cmd_proc i_kbc_cmd_proc (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .stat_rdata(stat_rdata),
        .obf_full_i(obf_full_i), .obf_aux_i(obf_aux_i),
        .push_valid(push_valid), .push_data(push_data), .push_aux(push_aux),
        .kbd_fwd_valid(kbd_fwd_valid), .mouse_fwd_valid(mouse_fwd_valid),
        .dev_data(dev_data), .a20_gate(a20_gate),
        .sys_reset_req(sys_reset_req), .cmd_err(cmd_err)
    );

    task automatic chk(input string tag, input logic [10:0] act, input logic [10:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_ev(input logic [1:0] kind, input logic aux, input logic [7:0] d);
        exp_q.push_back({kind, aux, d});
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic see(input logic [1:0] kind, input logic [10:0] got);
        if (exp_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R12 unexpected event actual=%h expected=none", got);
        end else begin
            chk($sformatf("R12 event kind %0d", kind), got, exp_q.pop_front());
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (push_valid)      see(2'd0, {2'd0, push_aux, push_data});
            if (kbd_fwd_valid)   see(2'd1, {2'd1, 1'b0, dev_data});
            if (mouse_fwd_valid) see(2'd2, {2'd2, 1'b0, dev_data});
            if (sys_reset_req)   see(2'd3, {2'd3, 1'b0, 8'h00});
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 status", {3'b0, stat_rdata}, 11'h018);
        chk("R1 a20", {10'b0, a20_gate}, 11'h1);
        chk("R1 err", {10'b0, cmd_err}, 11'h0);
        expect_ev(0, 0, 8'h03); wr(1, 8'h20);   // R1 mode
        expect_ev(0, 0, 8'hCF); wr(1, 8'hD0);   // R1 output port
        // R2 buffer-full bits
        obf_full_i = 1'b1; #1;
        chk("R2 status obf", {3'b0, stat_rdata}, 11'h019);
        obf_aux_i = 1'b1; #1;
        chk("R2 status aux obf", {3'b0, stat_rdata}, 11'h039);
        expect_ev(0, 0, 8'hFF); wr(1, 8'hD0);   // R6 port view with obf
        obf_full_i = 1'b0; obf_aux_i = 1'b0;
        // R4 plain data forward
        expect_ev(1, 0, 8'h55); wr(0, 8'h55);
        // R3 pending survives non-arming command, R5 mode load
        wr(1, 8'h60);
        expect_ev(0, 0, 8'h03); wr(1, 8'h20);
        wr(0, 8'h41);
        expect_ev(0, 0, 8'h41); wr(1, 8'h20);   // R5 mode loaded
        expect_ev(1, 0, 8'h12); wr(0, 8'h12);   // R3 pending cleared
        // R5 buffer and mouse writes
        wr(1, 8'hD2); expect_ev(0, 0, 8'hAB); wr(0, 8'hAB);
        wr(1, 8'hD3); expect_ev(0, 1, 8'h9C); wr(0, 8'h9C);
        wr(1, 8'hD4); expect_ev(2, 0, 8'hE8); wr(0, 8'hE8);
        // R6 read-back commands
        expect_ev(0, 0, 8'h80); wr(1, 8'hC0);
        expect_ev(0, 0, 8'h00); wr(1, 8'hA9);
        expect_ev(0, 0, 8'h00); wr(1, 8'hAB);
        expect_ev(0, 0, 8'h55); wr(1, 8'hAA);
        chk("R6 selftest status", {3'b0, stat_rdata}, 11'h01C);
        // R7 mode bits
        wr(1, 8'h60); wr(0, 8'h03);
        wr(1, 8'hA7); expect_ev(0, 0, 8'h23); wr(1, 8'h20);
        wr(1, 8'hAD); expect_ev(0, 0, 8'h33); wr(1, 8'h20);
        wr(1, 8'hA8); expect_ev(0, 0, 8'h13); wr(1, 8'h20);
        wr(1, 8'hAE); expect_ev(0, 0, 8'h03); wr(1, 8'h20);
        // R8 A20 commands
        wr(1, 8'hDD);
        chk("R8 a20 off", {10'b0, a20_gate}, 11'h0);
        expect_ev(0, 0, 8'hCD); wr(1, 8'hD0);
        wr(1, 8'hDF);
        chk("R8 a20 on", {10'b0, a20_gate}, 11'h1);
        // R9 output-port writes
        wr(1, 8'hD1); wr(0, 8'hCD);
        chk("R9 a20 from port", {10'b0, a20_gate}, 11'h0);
        wr(1, 8'hD1); expect_ev(3, 0, 8'h00); wr(0, 8'hCE);
        chk("R9 a20 from port", {10'b0, a20_gate}, 11'h1);
        expect_ev(0, 0, 8'hCE); wr(1, 8'hD0);
        wr(1, 8'hD1); wr(0, 8'hCF);
        // R10 pulse family
        expect_ev(3, 0, 8'h00); wr(1, 8'hF0);
        wr(1, 8'hF1);
        expect_ev(3, 0, 8'h00); wr(1, 8'hFE);
        wr(1, 8'hFF);
        expect_ev(3, 0, 8'h00); wr(1, 8'hFA);
        // R11 unknown command
        wr(1, 8'h42);
        chk("R11 err set", {10'b0, cmd_err}, 11'h1);
        chk("R11 status kept", {3'b0, stat_rdata}, 11'h01C);
        expect_ev(0, 0, 8'h03); wr(1, 8'h20);
        chk("R11 err sticky", {10'b0, cmd_err}, 11'h1);
        repeat (4) @(negedge clk);
        chk("R12 all events seen", {3'b0, 8'(exp_q.size())}, 11'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule